// File: doc/BRIEF.md
# Ultraviolet-Erasable Program Memory Mode Controller

This block is a synthesizable cycle model of a byte-wide, UV-erasable program store together with the logic that picks its operating mode. It takes an address, an active-low chip select, an active-low output gate and two flags. The first flag marks a raised programming supply. The second marks the raised voltage on the identification address pin. From these it selects one of seven modes: read, output gated off, standby, burn, burn check, burn blocked and the illegal burn-plus-read case. It then either drives a byte onto its output or leaves the output undriven.

The memory cells follow the physics of the real part. An erase sets every bit to 1, and a burn can only pull bits to 0. The chip select doubles as the burn strobe, so one burn happens on each falling edge of the sampled select while the device is in burn mode. The bidirectional data pins are split into an input byte, an output byte and an output drive enable. The full-size part uses a 15-bit address. The default parameters give a smaller array that keeps elaboration cheap.

All inputs are registered once, and the output byte and its drive enable are registered again. A change applied before rising edge k therefore appears on the outputs after rising edge k+1.

Top module: `uvprom_ctrl`

## Requirements
- R1: A one-cycle pulse on `erase_all` sets every location to all ones (0xFF for 8-bit data).
- R2: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=0 (read), the outputs drive the byte stored at `addr`, with `dout_en`=1, two rising edges after the inputs are applied.
- R3: With `vpp_hi`=0 and `ce_n`=1 (standby), `dout_en` is 0 whatever `oe_n` is.
- R4: With `vpp_hi`=0, `ce_n`=0 and `oe_n`=1 (output gated off), `dout_en` is 0.
- R5: With `vpp_hi`=1 and `oe_n`=1, a falling edge of the sampled `ce_n` stores (old AND `din`) at `addr`, exactly once per falling edge. Keeping `ce_n` low, or changing `din` while it is low, writes nothing further. The output stays undriven.
- R6: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=0 (burn check), the outputs drive the stored byte.
- R7: With `vpp_hi`=1, `ce_n`=1 and `oe_n`=1 (burn blocked), `dout_en` is 0 and the memory is unchanged.
- R8: When `id_hv`=1 in read or burn-check mode, the output is 0x8F if `addr[0]`=0 and 0x04 if `addr[0]`=1, whatever is stored.
- R9: With `vpp_hi`=1, `ce_n`=0 and `oe_n`=0, the output is undriven and no write takes place, even on a falling `ce_n`.
- R10: While `rst_n` is low, `dout_en` and `dout` are 0.
- R11: An erase pulse sampled in the same cycle as a burn strobe wins, and the location reads all ones afterwards.
- R12: Whenever `dout_en` is 0, `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rst_n | input | 1 | Asynchronous active-low reset of control and output registers |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Active-low chip select, also the burn strobe |
| oe_n | input | 1 | Active-low output gate |
| vpp_hi | input | 1 | Programming supply raised |
| id_hv | input | 1 | Identification pin at raised voltage |
| erase_all | input | 1 | Synchronous erase of the whole array |
| din | input | DATA_W | Byte presented on the data pins for burning |
| dout | output | DATA_W | Byte driven on the data pins |
| dout_en | output | 1 | Data pin drive enable |

## Verification
The assertions assume that all inputs are synchronous to the clock and that each burn addresses a single location, which is held until the next sampled cycle. The stimulus changes inputs only at falling clock edges and holds each setting for two rising edges before the outputs are sampled. During the sweep over every mode, flag and `addr[0]` combination, `din` is held at all ones, so any burn strobe that the sweep happens to produce leaves the stored contents untouched. A bench-side model of the array is updated only by the AND rule and by erase.

// File: rtl/uvprom_pkg.sv
`timescale 1ns/1ps
package uvprom_pkg;

   typedef enum logic [2:0] {
      MODE_READ,
      MODE_GATED,
      MODE_SLEEP,
      MODE_BURN,
      MODE_CHECK,
      MODE_BLOCK,
      MODE_CLASH
   } mode_t;

   function automatic logic mode_drives(mode_t m);
      return (m == MODE_READ) || (m == MODE_CHECK);
   endfunction

   function automatic logic mode_burns(mode_t m);
      return (m == MODE_BURN);
   endfunction

endpackage

// File: rtl/uvprom_sample.sv
`timescale 1ns/1ps
module uvprom_sample #(
   parameter int ADDR_W     = 10,
   parameter int DATA_W     = 8,
   parameter bit REG_INPUTS = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              ce_n_i,
   input  logic              oe_n_i,
   input  logic              vpp_i,
   input  logic              id_i,
   input  logic              erase_i,
   input  logic [DATA_W-1:0] din_i,
   output logic [ADDR_W-1:0] addr_q,
   output logic              ce_n_q,
   output logic              oe_n_q,
   output logic              vpp_q,
   output logic              id_q,
   output logic              erase_q,
   output logic [DATA_W-1:0] din_q,
   output logic              strobe_fall
);

   logic ce_n_prev;

   generate
      if (REG_INPUTS) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               addr_q  <= '0;
               ce_n_q  <= 1'b1;
               oe_n_q  <= 1'b1;
               vpp_q   <= 1'b0;
               id_q    <= 1'b0;
               erase_q <= 1'b0;
               din_q   <= '0;
            end else begin
               addr_q  <= addr_i;
               ce_n_q  <= ce_n_i;
               oe_n_q  <= oe_n_i;
               vpp_q   <= vpp_i;
               id_q    <= id_i;
               erase_q <= erase_i;
               din_q   <= din_i;
            end
         end
      end else begin : g_pass
         assign addr_q  = addr_i;
         assign ce_n_q  = ce_n_i;
         assign oe_n_q  = oe_n_i;
         assign vpp_q   = vpp_i;
         assign id_q    = id_i;
         assign erase_q = erase_i;
         assign din_q   = din_i;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ce_n_prev <= 1'b1;
      else        ce_n_prev <= ce_n_q;
   end

   assign strobe_fall = ce_n_prev & ~ce_n_q;

endmodule

// File: rtl/uvprom_decode.sv
`timescale 1ns/1ps
module uvprom_decode
   import uvprom_pkg::*;
(
   input  logic  ce_n,
   input  logic  oe_n,
   input  logic  vpp,
   output mode_t mode
);

   always_comb begin
      if (!vpp) begin
         if (ce_n)      mode = MODE_SLEEP;
         else if (oe_n) mode = MODE_GATED;
         else           mode = MODE_READ;
      end else begin
         unique case ({ce_n, oe_n})
            2'b01:   mode = MODE_BURN;
            2'b10:   mode = MODE_CHECK;
            2'b11:   mode = MODE_BLOCK;
            default: mode = MODE_CLASH;
         endcase
      end
   end

endmodule

// File: rtl/uvprom_array.sv
`timescale 1ns/1ps
module uvprom_array #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              erase,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (erase) begin
         for (int i = 0; i < DEPTH; i++) cells[i] <= '1;
      end else if (we) begin
         cells[addr] <= cells[addr] & wdata;
      end
   end

   assign rdata = cells[addr];

   // R1: after an erase the addressed word reads all ones
   a_r1_erase_ones: assert property (@(posedge clk) disable iff (!rst_n)
      erase |=> (rdata == '1));

   // R5: a burn never raises a bit at the same location
   a_r5_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !erase) |=> ((addr != $past(addr)) || ((rdata & ~$past(rdata)) == '0)));

endmodule

// File: rtl/uvprom_ctrl.sv
`timescale 1ns/1ps
module uvprom_ctrl
   import uvprom_pkg::*;
#(
   parameter int              ADDR_W     = 10,
   parameter int              DATA_W     = 8,
   parameter bit              REG_INPUTS = 1'b1,
   parameter logic [DATA_W-1:0] MFR_CODE = 'h8F,
   parameter logic [DATA_W-1:0] DEV_CODE = 'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              vpp_hi,
   input  logic              id_hv,
   input  logic              erase_all,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_en
);

   generate
      if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_addr
         $error("uvprom_ctrl: ADDR_W must lie in 1..16");
      end
      if (DATA_W < 1 || DATA_W > 64) begin : g_bad_data
         $error("uvprom_ctrl: DATA_W must lie in 1..64");
      end
   endgenerate

   logic [ADDR_W-1:0] addr_q;
   logic              ce_q, oe_q, vpp_q, id_q, erase_q, fall;
   logic [DATA_W-1:0] din_q, rdata, id_word;
   mode_t             mode;
   logic              drive, we;

   uvprom_sample #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_INPUTS(REG_INPUTS)
   ) u_sample (
      .clk(clk), .rst_n(rst_n),
      .addr_i(addr), .ce_n_i(ce_n), .oe_n_i(oe_n), .vpp_i(vpp_hi),
      .id_i(id_hv), .erase_i(erase_all), .din_i(din),
      .addr_q(addr_q), .ce_n_q(ce_q), .oe_n_q(oe_q), .vpp_q(vpp_q),
      .id_q(id_q), .erase_q(erase_q), .din_q(din_q), .strobe_fall(fall)
   );

   uvprom_decode u_decode (
      .ce_n(ce_q), .oe_n(oe_q), .vpp(vpp_q), .mode(mode)
   );

   assign drive = mode_drives(mode);
   assign we    = fall && mode_burns(mode);

   uvprom_array #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_array (
      .clk(clk), .rst_n(rst_n), .erase(erase_q), .we(we),
      .addr(addr_q), .wdata(din_q), .rdata(rdata)
   );

   assign id_word = addr_q[0] ? DEV_CODE : MFR_CODE;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout_en <= 1'b0;
         dout    <= '0;
      end else begin
         dout_en <= drive;
         dout    <= drive ? (id_q ? id_word : rdata) : '0;
      end
   end

   a_r3_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (ce_q && !vpp_q) |=> !dout_en);

   a_r4_gated_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_q && !vpp_q && !ce_q) |=> !dout_en);

   a_r7_block_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_q && ce_q && oe_q) |=> !dout_en);

   a_r9_clash_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (vpp_q && !ce_q && !oe_q) |=> !dout_en);

   a_r8_id_value: assert property (@(posedge clk) disable iff (!rst_n)
      (id_q && !oe_q && (ce_q == vpp_q)) |=>
         (dout == ($past(addr_q[0]) ? DEV_CODE : MFR_CODE)));

   a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_en |-> (dout == '0));

endmodule

// File: tb/test_uvprom_ctrl.sv
`timescale 1ns/1ps
module test_uvprom_ctrl;

   localparam int AW    = 10;
   localparam int DW    = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          ce_n = 1'b1, oe_n = 1'b1, vpp_hi = 1'b0, id_hv = 1'b0, erase_all = 1'b0;
   logic [DW-1:0] din = '0;
   logic [DW-1:0] dout;
   logic          dout_en;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic [DW-1:0] model [DEPTH];

   always #2 clk = ~clk;

   uvprom_ctrl i_uvprom_ctrl (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
      .vpp_hi(vpp_hi), .id_hv(id_hv), .erase_all(erase_all), .din(din),
      .dout(dout), .dout_en(dout_en)
   );

   task automatic check(input string req, input logic en_a, input logic en_e,
                        input logic [DW-1:0] d_a, input logic [DW-1:0] d_e);
      checks++;
      if (en_a !== en_e || d_a !== d_e) begin
         errors++;
         $display("FAIL %s: en=%b data=%h, expected en=%b data=%h", req, en_a, d_a, en_e, d_e);
      end
   endtask

   task automatic drive(input logic v, input logic c, input logic o, input logic i,
                        input logic [AW-1:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      vpp_hi = v; ce_n = c; oe_n = o; id_hv = i; addr = a; din = d;
      repeat (2) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic burn_byte(input logic [AW-1:0] a, input logic [DW-1:0] d);
      drive(1, 1, 1, 0, a, d);
      drive(1, 0, 1, 0, a, d);
      drive(1, 1, 1, 0, a, d);
      model[a] = model[a] & d;
   endtask

   task automatic read_chk(input string req, input logic [AW-1:0] a, input logic verify);
      if (verify) drive(1, 1, 0, 0, a, '1);
      else        drive(0, 0, 0, 0, a, '1);
      check(req, dout_en, 1'b1, dout, model[a]);
   endtask

   task automatic erase_pulse();
      @(negedge clk);
      erase_all = 1'b1;
      @(negedge clk);
      erase_all = 1'b0;
      for (int k = 0; k < DEPTH; k++) model[k] = '1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R10", dout_en, 1'b0, dout, '0);
      rst_n = 1'b1;

      // R1: erase, then every location reads all ones in read mode (R2)
      erase_pulse();
      for (int a = 0; a < DEPTH; a++) read_chk("R1", a[AW-1:0], 1'b0);

      // first pattern into every location, checked in burn-check mode (R6)
      for (int a = 0; a < DEPTH; a++) burn_byte(a[AW-1:0], DW'((a * 37 + 11) & 8'hFF));
      for (int a = 0; a < DEPTH; a++) read_chk("R6", a[AW-1:0], 1'b1);
      for (int a = 0; a < DEPTH; a += 7) read_chk("R2", a[AW-1:0], 1'b0);

      // R5: second pattern on a subset can only clear bits
      for (int a = 0; a < DEPTH; a += 3) burn_byte(a[AW-1:0], DW'((a ^ 8'h5A) & 8'hFF));
      for (int a = 0; a < DEPTH; a++) read_chk("R5", a[AW-1:0], 1'b1);

      // R5: holding the strobe low and changing din writes nothing more
      erase_pulse();
      drive(1, 1, 1, 0, 5, 8'h3C);
      drive(1, 0, 1, 0, 5, 8'h3C);
      check("R5", dout_en, 1'b0, dout, '0);
      drive(1, 0, 1, 0, 5, 8'h00);
      drive(1, 0, 1, 0, 5, 8'h00);
      drive(1, 1, 1, 0, 5, 8'h00);
      model[5] = 8'h3C;
      read_chk("R5", 5, 1'b1);

      // R7: both enables high with raised supply: quiet, no write
      drive(1, 1, 1, 0, 7, 8'h00);
      check("R7", dout_en, 1'b0, dout, '0);
      drive(0, 1, 1, 0, 7, 8'h00);
      read_chk("R7", 7, 1'b0);

      // R9: strobe falls with the output gate low under raised supply
      drive(1, 1, 0, 0, 11, 8'h00);
      drive(1, 0, 0, 0, 11, 8'h00);
      check("R9", dout_en, 1'b0, dout, '0);
      drive(1, 1, 0, 0, 11, 8'h00);
      check("R9", dout_en, 1'b1, dout, model[11]);

      // sweep of every mode, flag and addr[0] combination, din held at all ones
      burn_byte(12, 8'hA5);
      burn_byte(13, 8'h69);
      for (int c = 0; c < 32; c++) begin
         logic v, ce, oe, idv, a0, en_e;
         logic [DW-1:0] d_e;
         string tag;
         v = c[4]; ce = c[3]; oe = c[2]; idv = c[1]; a0 = c[0];
         drive(v, ce, oe, idv, {{(AW-1){1'b0}}, 1'b0} | AW'(12 + a0), 8'hFF);
         en_e = (!v && !ce && !oe) || (v && ce && !oe);
         d_e  = !en_e ? 8'h00 : (idv ? (a0 ? 8'h04 : 8'h8F) : model[12 + a0]);
         if (!v && ce)              tag = "R3";
         else if (!v && oe)         tag = "R4";
         else if (v && ce && oe)    tag = "R7";
         else if (v && !ce && !oe)  tag = "R9";
         else if (v && !ce)         tag = "R5";
         else if (idv)              tag = "R8";
         else if (v)                tag = "R6";
         else                       tag = "R2";
         check(tag, dout_en, en_e, dout, d_e);
      end
      drive(0, 1, 0, 0, 12, 8'hFF);
      check("R12", dout_en, 1'b0, dout, 8'h00);

      // R11: erase and burn strobe sampled together, erase wins
      drive(1, 1, 1, 0, 9, 8'h00);
      @(negedge clk);
      erase_all = 1'b1;
      ce_n = 1'b0;
      @(negedge clk);
      erase_all = 1'b0;
      repeat (2) @(negedge clk);
      drive(1, 1, 1, 0, 9, 8'h00);
      for (int k = 0; k < DEPTH; k++) model[k] = '1;
      read_chk("R11", 9, 1'b1);
      read_chk("R1", 20, 1'b0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule